// File: doc/BRIEF.md
# Switch Ingress Forwarding Decision

This block makes the forwarding decision for each packet that enters a small multi-port Ethernet switch. The switch has one host port (index `HOST`, 0 by default) and several external ports. The block does not perform the lookup itself. An address-table lookup stage works out the facts about the packet, and this block receives them:

- whether the source address is known, whether it is static, and its stored port;
- whether the destination is known, and its port;
- whether the destination is multicast, and its super-entry bit;
- the OUI match and the supervisory-destination match;
- whether the VLAN is known, and its member mask;
- the frame's tag information.

The block also receives the ingress port and a configuration word. From these it builds a destination port mask, a drop flag and a to-host flag. It also tells the table whether to learn the source address, and on which port. Table storage, hashing and frame parsing stay outside the block.

The policy is applied in a fixed priority order:

1. the global enable;
2. the bypass-to-host mode;
3. the authorization check;
4. the OUI filter;
5. normal forwarding, which is either VLAN-aware or simple flooding.

After the policy, the ingress port is always removed from the mask. An input strobe produces a registered result, with a one-cycle output strobe, on the next clock edge.

Configuration word `in_cfg` bit positions: 0 enable, 1 bypass, 2 authorization, 3 OUI deny, 4 VLAN aware, 5 flood unknown unicast to host, 6 no learning on unknown VLAN, 7 priority-tagged frames use VID 0, 8 allow static entries to move.

Top module: `fwd_decide`

## Requirements
- R1: With cfg bit 0 (enable) clear, the result has an all-zero mask, drop set and learn clear, whatever the other inputs are.
- R2: With cfg bit 1 (bypass) set, a packet from a non-host port goes to the host port only, with to-host set. A packet from the host port goes to the port given on `in_host_dest`. No learning happens in bypass.
- R3: With cfg bit 2 (authorization) set, learning never happens. A packet whose source address is not found is dropped, unless its destination is multicast with the super-entry bit set.
- R4: A packet is diverted to the host port only when both of the following hold: (a) either cfg bit 3 (OUI deny) is set and the OUI does not match, or cfg bit 3 is clear and the OUI matches; and (b) the destination did not hit a supervisory entry.
- R5: A known unicast destination goes to its table port. With cfg bit 4 (VLAN aware) set, that port must also be in the VLAN member mask, otherwise the packet is dropped.
- R6: Multicast and unknown destinations flood to all ports when cfg bit 4 is clear, and to the VLAN member ports only when it is set.
- R7: An unknown unicast flood includes the host port only when cfg bit 5 is set.
- R8: The ingress port is never in the output mask. Drop is set exactly when the mask is empty, and to-host equals the host bit of the mask.
- R9: With cfg bit 6 set, no learning happens for a packet whose VLAN is unknown.
- R10: Outside R1–R3 and R9, learning happens in two cases: the source address is new, or the address moved to another port and is either non-static or cfg bit 8 is set. Learning is independent of the drop decision, and the learn port is the ingress port.
- R11: The output VID is the frame VID for tagged frames. For priority-tagged frames it is 0 when cfg bit 7 is set, otherwise the ingress port's default VID.
- R12: The result and `out_valid` appear on the clock edge after `in_valid`, with `out_valid` high for exactly one cycle per strobe. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup result strobe |
| in_src_port | input | PW | Ingress port |
| in_cfg | input | 9 | Configuration word |
| in_host_dest | input | PW | Egress port named by the host in bypass |
| in_sa_found | input | 1 | Source address present in table |
| in_sa_static | input | 1 | Source entry is non-ageable |
| in_sa_port | input | PW | Port stored with the source entry |
| in_da_found | input | 1 | Destination address present in table |
| in_da_port | input | PW | Port stored with the destination entry |
| in_da_mcast | input | 1 | Destination is multicast |
| in_da_super | input | 1 | Destination entry has the super bit |
| in_oui_hit | input | 1 | Source OUI matched an OUI entry |
| in_sup_hit | input | 1 | Destination matched a supervisory entry |
| in_vlan_known | input | 1 | VID present in table |
| in_vlan_members | input | NP | VLAN member port mask |
| in_pri_tagged | input | 1 | Frame is priority-tagged (VID field zero) |
| in_pkt_vid | input | VID_W | VID carried in the frame |
| in_dflt_vid | input | VID_W | Ingress port default VID |
| out_valid | output | 1 | Result strobe |
| out_mask | output | NP | Egress port mask |
| out_drop | output | 1 | Packet dropped (empty mask) |
| out_to_host | output | 1 | Host port is in the mask |
| out_learn | output | 1 | Table should learn the source |
| out_learn_port | output | PW | Port to learn |
| out_vid | output | VID_W | Effective VID |

## Verification
The bench starts with directed packets, one for each policy level. Each one is placed so that only one priority stage decides the outcome. This separates, for example, an OUI diversion from a supervisory exception, an authorization drop from the multicast-super exception, and a VLAN-restricted flood from a plain flood. It then tries unicast sent to the ingress port itself, static entries that move with and without the update bit, and both priority-tag VID choices. A long run of random lookup results follows, sent back to back and with gaps. It mixes every configuration bit, so that interactions between the priority levels and the strobe timing are compared against an independent per-port model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int CFG_W = 9;

    // First field is the most significant bit: enable lands on bit 0.
    typedef struct packed {
        logic upd_static;
        logic pri_vid0;
        logic unk_vlan_nolearn;
        logic flood_host;
        logic vlan_aware;
        logic oui_deny;
        logic auth;
        logic bypass;
        logic enable;
    } fwd_cfg_t;

    typedef enum logic [2:0] {
        PATH_OFF    = 3'd0,
        PATH_BYPASS = 3'd1,
        PATH_DENY   = 3'd2,
        PATH_DIVERT = 3'd3,
        PATH_FWD    = 3'd4
    } fwd_path_e;

    function automatic logic oui_blocks(input logic deny_mode, input logic hit);
        return deny_mode ? !hit : hit;
    endfunction

endpackage

// File: rtl/fwd_vid_sel.sv
module fwd_vid_sel #(
    parameter int VID_W = 12
) (
    input  logic             pri_tagged,
    input  logic             use_zero,
    input  logic [VID_W-1:0] pkt_vid,
    input  logic [VID_W-1:0] dflt_vid,
    output logic [VID_W-1:0] vid
);
    always_comb begin
        if (!pri_tagged)
            vid = pkt_vid;
        else if (use_zero)
            vid = '0;
        else
            vid = dflt_vid;
    end
endmodule

// File: rtl/fwd_policy.sv
module fwd_policy
    import fwd_pkg::*;
#(
    parameter int NP   = 4,
    parameter int PW   = 2,
    parameter int HOST = 0
) (
    input  fwd_cfg_t        cfg,
    input  logic [PW-1:0]   src_port,
    input  logic [PW-1:0]   host_dest,
    input  logic            sa_found,
    input  logic            da_found,
    input  logic [PW-1:0]   da_port,
    input  logic            da_mcast,
    input  logic            da_super,
    input  logic            oui_hit,
    input  logic            sup_hit,
    input  logic [NP-1:0]   vlan_members,
    output logic [NP-1:0]   mask
);
    localparam logic [NP-1:0] HOST_BIT = NP'(1) << HOST;

    fwd_path_e     path;
    logic [NP-1:0] reach;
    logic [NP-1:0] fwd_mask;

    // Priority: enable, bypass, authorization, OUI filter, forwarding.
    always_comb begin
        if (!cfg.enable)
            path = PATH_OFF;
        else if (cfg.bypass)
            path = PATH_BYPASS;
        else if (cfg.auth && !sa_found && !(da_mcast && da_super))
            path = PATH_DENY;
        else if (oui_blocks(cfg.oui_deny, oui_hit) && !sup_hit)
            path = PATH_DIVERT;
        else
            path = PATH_FWD;
    end

    assign reach = cfg.vlan_aware ? vlan_members : '1;

    always_comb begin
        if (da_mcast)
            fwd_mask = reach;
        else if (da_found)
            fwd_mask = (NP'(1) << da_port) & reach;
        else if (cfg.flood_host)
            fwd_mask = reach;
        else
            fwd_mask = reach & ~HOST_BIT;
    end

    always_comb begin
        case (path)
            PATH_BYPASS: mask = (src_port == PW'(HOST)) ? (NP'(1) << host_dest) : HOST_BIT;
            PATH_DIVERT: mask = HOST_BIT;
            PATH_FWD:    mask = fwd_mask;
            default:     mask = '0;
        endcase
    end
endmodule

// File: rtl/fwd_learn_gate.sv
module fwd_learn_gate
    import fwd_pkg::*;
#(
    parameter int PW = 2
) (
    input  fwd_cfg_t      cfg,
    input  logic [PW-1:0] src_port,
    input  logic          sa_found,
    input  logic          sa_static,
    input  logic [PW-1:0] sa_port,
    input  logic          vlan_known,
    output logic          learn
);
    logic allowed;
    logic moved;
    logic movable;

    assign allowed = cfg.enable && !cfg.bypass && !cfg.auth
                     && !(cfg.unk_vlan_nolearn && !vlan_known);
    assign moved   = sa_port != src_port;
    assign movable = !sa_static || cfg.upd_static;
    assign learn   = allowed && (!sa_found || (moved && movable));
endmodule

// File: rtl/fwd_decide.sv
module fwd_decide
    import fwd_pkg::*;
#(
    parameter int NP    = 4,
    parameter int HOST  = 0,
    parameter int VID_W = 12,
    parameter int PW    = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PW-1:0]    in_src_port,
    input  logic [CFG_W-1:0] in_cfg,
    input  logic [PW-1:0]    in_host_dest,
    input  logic             in_sa_found,
    input  logic             in_sa_static,
    input  logic [PW-1:0]    in_sa_port,
    input  logic             in_da_found,
    input  logic [PW-1:0]    in_da_port,
    input  logic             in_da_mcast,
    input  logic             in_da_super,
    input  logic             in_oui_hit,
    input  logic             in_sup_hit,
    input  logic             in_vlan_known,
    input  logic [NP-1:0]    in_vlan_members,
    input  logic             in_pri_tagged,
    input  logic [VID_W-1:0] in_pkt_vid,
    input  logic [VID_W-1:0] in_dflt_vid,
    output logic             out_valid,
    output logic [NP-1:0]    out_mask,
    output logic             out_drop,
    output logic             out_to_host,
    output logic             out_learn,
    output logic [PW-1:0]    out_learn_port,
    output logic [VID_W-1:0] out_vid
);
    fwd_cfg_t         cfg;
    logic [NP-1:0]    pol_mask;
    logic [NP-1:0]    strip;
    logic             learn_d;
    logic [VID_W-1:0] vid_d;

    assign cfg = fwd_cfg_t'(in_cfg);

    fwd_policy #(.NP(NP), .PW(PW), .HOST(HOST)) u_policy (
        .cfg          (cfg),
        .src_port     (in_src_port),
        .host_dest    (in_host_dest),
        .sa_found     (in_sa_found),
        .da_found     (in_da_found),
        .da_port      (in_da_port),
        .da_mcast     (in_da_mcast),
        .da_super     (in_da_super),
        .oui_hit      (in_oui_hit),
        .sup_hit      (in_sup_hit),
        .vlan_members (in_vlan_members),
        .mask         (pol_mask)
    );

    fwd_learn_gate #(.PW(PW)) u_learn (
        .cfg        (cfg),
        .src_port   (in_src_port),
        .sa_found   (in_sa_found),
        .sa_static  (in_sa_static),
        .sa_port    (in_sa_port),
        .vlan_known (in_vlan_known),
        .learn      (learn_d)
    );

    fwd_vid_sel #(.VID_W(VID_W)) u_vid (
        .pri_tagged (in_pri_tagged),
        .use_zero   (cfg.pri_vid0),
        .pkt_vid    (in_pkt_vid),
        .dflt_vid   (in_dflt_vid),
        .vid        (vid_d)
    );

    // No reflection: the ingress port bit is cleared after every policy path.
    for (genvar i = 0; i < NP; i++) begin : g_strip
        assign strip[i] = pol_mask[i] && (in_src_port != PW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid      <= 1'b0;
            out_mask       <= '0;
            out_drop       <= 1'b0;
            out_to_host    <= 1'b0;
            out_learn      <= 1'b0;
            out_learn_port <= '0;
            out_vid        <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask       <= strip;
                out_drop       <= (strip == '0);
                out_to_host    <= strip[HOST];
                out_learn      <= learn_d;
                out_learn_port <= in_src_port;
                out_vid        <= vid_d;
            end
        end
    end
endmodule

// File: rtl/fwd_decide_chk.sv
module fwd_decide_chk #(
    parameter int NP   = 4,
    parameter int PW   = 2,
    parameter int HOST = 0
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [PW-1:0] in_src_port,
    input logic [8:0]    in_cfg,
    input logic          out_valid,
    input logic [NP-1:0] out_mask,
    input logic          out_drop,
    input logic          out_to_host,
    input logic          out_learn,
    input logic [PW-1:0] out_learn_port
);
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r1_off_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_cfg[0]) |=> (out_drop && out_mask == '0 && !out_learn));

    a_r2_bypass_to_host: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cfg[0] && in_cfg[1] && in_src_port != PW'(HOST))
        |=> (out_mask == (NP'(1) << HOST) && out_to_host && !out_learn));

    a_r3_auth_no_learn: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cfg[2]) |=> !out_learn);

    a_r8_no_reflect: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !out_mask[$past(in_src_port)]);

    a_r10_learn_port: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!out_learn || out_learn_port == $past(in_src_port)));
endmodule

bind fwd_decide fwd_decide_chk #(.NP(NP), .PW(PW), .HOST(HOST)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_src_port    (in_src_port),
    .in_cfg         (in_cfg),
    .out_valid      (out_valid),
    .out_mask       (out_mask),
    .out_drop       (out_drop),
    .out_to_host    (out_to_host),
    .out_learn      (out_learn),
    .out_learn_port (out_learn_port)
);

// File: tb/fwd_decide_test.sv
module fwd_decide_test;

    localparam int NP = 4;
    localparam int PW = 2;
    localparam int VW = 12;

    // cfg bit positions
    localparam int C_EN = 0, C_BYP = 1, C_AUTH = 2, C_ODENY = 3, C_VAW = 4,
                   C_FH = 5, C_NOLRN = 6, C_VID0 = 7, C_UPD = 8;

    typedef struct {
        logic [PW-1:0] src;
        logic [8:0]    cfg;
        logic [PW-1:0] hdest;
        logic          sa_found, sa_static;
        logic [PW-1:0] sa_port;
        logic          da_found;
        logic [PW-1:0] da_port;
        logic          da_mcast, da_super, oui_hit, sup_hit, vlan_known;
        logic [NP-1:0] members;
        logic          pri;
        logic [VW-1:0] pvid, dvid;
    } stim_t;

    typedef struct {
        logic [NP-1:0] mask;
        logic          drop, to_host, learn;
        logic [PW-1:0] lport;
        logic [VW-1:0] vid;
        int            due;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [PW-1:0]    in_src_port = '0;
    logic [8:0]       in_cfg = '0;
    logic [PW-1:0]    in_host_dest = '0;
    logic             in_sa_found = 1'b0, in_sa_static = 1'b0;
    logic [PW-1:0]    in_sa_port = '0;
    logic             in_da_found = 1'b0;
    logic [PW-1:0]    in_da_port = '0;
    logic             in_da_mcast = 1'b0, in_da_super = 1'b0;
    logic             in_oui_hit = 1'b0, in_sup_hit = 1'b0, in_vlan_known = 1'b0;
    logic [NP-1:0]    in_vlan_members = '0;
    logic             in_pri_tagged = 1'b0;
    logic [VW-1:0]    in_pkt_vid = '0, in_dflt_vid = '0;
    logic             out_valid, out_drop, out_to_host, out_learn;
    logic [NP-1:0]    out_mask;
    logic [PW-1:0]    out_learn_port;
    logic [VW-1:0]    out_vid;

    int   cyc = 0;
    int   vectors = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fwd_decide #(.NP(NP), .HOST(0), .VID_W(VW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src_port(in_src_port),
        .in_cfg(in_cfg), .in_host_dest(in_host_dest), .in_sa_found(in_sa_found),
        .in_sa_static(in_sa_static), .in_sa_port(in_sa_port), .in_da_found(in_da_found),
        .in_da_port(in_da_port), .in_da_mcast(in_da_mcast), .in_da_super(in_da_super),
        .in_oui_hit(in_oui_hit), .in_sup_hit(in_sup_hit), .in_vlan_known(in_vlan_known),
        .in_vlan_members(in_vlan_members), .in_pri_tagged(in_pri_tagged),
        .in_pkt_vid(in_pkt_vid), .in_dflt_vid(in_dflt_vid), .out_valid(out_valid),
        .out_mask(out_mask), .out_drop(out_drop), .out_to_host(out_to_host),
        .out_learn(out_learn), .out_learn_port(out_learn_port), .out_vid(out_vid)
    );

    // Reference model, built port by port from the requirements.
    function automatic exp_t predict(stim_t s);
        exp_t e;
        bit en, byp, blocked;
        en  = s.cfg[C_EN];
        byp = s.cfg[C_BYP];
        blocked = s.cfg[C_ODENY] ? !s.oui_hit : s.oui_hit;
        e.mask = '0;
        if (!en) begin
            e.mask = '0;                                         // R1
        end else if (byp) begin
            if (s.src == 0) e.mask[s.hdest] = 1'b1;              // R2
            else            e.mask[0] = 1'b1;
        end else if (s.cfg[C_AUTH] && !s.sa_found && !(s.da_mcast && s.da_super)) begin
            e.mask = '0;                                         // R3
        end else if (blocked && !s.sup_hit) begin
            e.mask[0] = 1'b1;                                    // R4
        end else begin
            for (int p = 0; p < NP; p++) begin
                bit go;
                if (s.da_mcast)      go = 1'b1;                  // R6
                else if (s.da_found) go = (p == int'(s.da_port)); // R5
                else                 go = (p != 0) || s.cfg[C_FH]; // R6, R7
                if (s.cfg[C_VAW] && !s.members[p]) go = 1'b0;
                e.mask[p] = go;
            end
        end
        e.mask[s.src] = 1'b0;                                    // R8
        e.drop    = (e.mask == '0);
        e.to_host = e.mask[0];
        e.learn   = en && !byp && !s.cfg[C_AUTH]
                    && !(s.cfg[C_NOLRN] && !s.vlan_known)        // R9
                    && (!s.sa_found || (s.sa_port != s.src
                        && (!s.sa_static || s.cfg[C_UPD])));     // R10
        e.lport   = s.src;
        if (!s.pri)              e.vid = s.pvid;                 // R11
        else if (s.cfg[C_VID0])  e.vid = '0;
        else                     e.vid = s.dvid;
        return e;
    endfunction

    task automatic send(stim_t s, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_src_port = s.src; in_cfg = s.cfg; in_host_dest = s.hdest;
        in_sa_found = s.sa_found; in_sa_static = s.sa_static; in_sa_port = s.sa_port;
        in_da_found = s.da_found; in_da_port = s.da_port; in_da_mcast = s.da_mcast;
        in_da_super = s.da_super; in_oui_hit = s.oui_hit; in_sup_hit = s.sup_hit;
        in_vlan_known = s.vlan_known; in_vlan_members = s.members;
        in_pri_tagged = s.pri; in_pkt_vid = s.pvid; in_dflt_vid = s.dvid;
        e = predict(s);
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic stim_t base();
        stim_t s;
        s.src = 2'd1; s.cfg = 9'b0_0000_0001; s.hdest = 2'd0;
        s.sa_found = 1'b1; s.sa_static = 1'b0; s.sa_port = 2'd1;
        s.da_found = 1'b1; s.da_port = 2'd2; s.da_mcast = 1'b0; s.da_super = 1'b0;
        s.oui_hit = 1'b0; s.sup_hit = 1'b0; s.vlan_known = 1'b1; s.members = 4'b1111;
        s.pri = 1'b0; s.pvid = 12'h123; s.dvid = 12'h456;
        return s;
    endfunction

    // Monitor: result due one edge after its strobe, silent otherwise (R12).
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                vectors++;
                if (out_valid !== 1'b1 || out_mask !== e.mask || out_drop !== e.drop
                    || out_to_host !== e.to_host || out_learn !== e.learn
                    || (e.learn && out_learn_port !== e.lport) || out_vid !== e.vid) begin
                    fails++;
                    $display("FAIL %s: got v=%b mask=%b drop=%b host=%b learn=%b lp=%0d vid=%h exp mask=%b drop=%b host=%b learn=%b lp=%0d vid=%h",
                             e.tag, out_valid, out_mask, out_drop, out_to_host, out_learn,
                             out_learn_port, out_vid, e.mask, e.drop, e.to_host, e.learn,
                             e.lport, e.vid);
                end
            end else if (out_valid !== 1'b0) begin
                vectors++;
                fails++;
                $display("FAIL R12: got out_valid=%b exp 0", out_valid);
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || out_mask !== '0 || out_learn !== 1'b0 || out_vid !== '0) begin
            fails++;
            $display("FAIL R12: reset got v=%b mask=%b learn=%b exp 0 0 0", out_valid, out_mask, out_learn);
        end

        s = base();                                  send(s, "R5 known unicast");
        s = base(); s.cfg[C_EN] = 0;                 send(s, "R1 disabled");
        s = base(); s.cfg[C_BYP] = 1; s.src = 2;     send(s, "R2 bypass from external");
        s = base(); s.cfg[C_BYP] = 1; s.src = 0; s.hdest = 3; send(s, "R2 bypass from host");
        s = base(); s.cfg[C_AUTH] = 1; s.sa_found = 0; send(s, "R3 auth unknown source");
        idle(1);
        s = base(); s.cfg[C_AUTH] = 1; s.sa_found = 0; s.da_mcast = 1; s.da_super = 1;
        send(s, "R3 auth super multicast");
        s = base(); s.cfg[C_ODENY] = 1;              send(s, "R4 deny mode no OUI hit");
        s = base(); s.cfg[C_ODENY] = 1; s.sup_hit = 1; send(s, "R4 supervisory exception");
        s = base(); s.oui_hit = 1;                   send(s, "R4 allow mode OUI hit");
        s = base(); s.da_found = 0; s.cfg[C_VAW] = 1; s.members = 4'b0110;
        send(s, "R6 VLAN restricted flood");
        s = base(); s.da_found = 0;                  send(s, "R7 flood without host");
        s = base(); s.da_found = 0; s.cfg[C_FH] = 1; send(s, "R7 flood with host");
        s = base(); s.da_mcast = 1;                  send(s, "R6 multicast flood");
        s = base(); s.da_port = 1;                   send(s, "R8 unicast to ingress port");
        s = base(); s.cfg[C_VAW] = 1; s.members = 4'b1011; send(s, "R5 destination not a member");
        s = base(); s.sa_found = 0;                  send(s, "R10 new source");
        s = base(); s.sa_port = 3;                   send(s, "R10 moved dynamic");
        s = base(); s.sa_port = 3; s.sa_static = 1;  send(s, "R10 moved static locked");
        s = base(); s.sa_port = 3; s.sa_static = 1; s.cfg[C_UPD] = 1; send(s, "R10 moved static allowed");
        s = base(); s.sa_found = 0; s.cfg[C_NOLRN] = 1; s.vlan_known = 0; send(s, "R9 unknown VLAN no learn");
        s = base(); s.sa_found = 0; s.cfg[C_NOLRN] = 1; send(s, "R9 known VLAN learns");
        s = base(); s.pri = 1; s.cfg[C_VID0] = 1;    send(s, "R11 priority tag VID 0");
        s = base(); s.pri = 1;                       send(s, "R11 priority tag default VID");
        idle(2);

        for (int n = 0; n < 600; n++) begin
            stim_t r;
            r.src = PW'($urandom); r.cfg = 9'($urandom) | 9'b1; r.hdest = PW'($urandom);
            if ($urandom_range(0, 7) == 0) r.cfg[C_EN] = 0;
            if ($urandom_range(0, 2) != 0) r.cfg[C_BYP] = 0;
            r.sa_found = 1'($urandom); r.sa_static = 1'($urandom); r.sa_port = PW'($urandom);
            r.da_found = 1'($urandom); r.da_port = PW'($urandom); r.da_mcast = 1'($urandom);
            r.da_super = 1'($urandom); r.oui_hit = 1'($urandom); r.sup_hit = 1'($urandom);
            r.vlan_known = 1'($urandom); r.members = NP'($urandom);
            r.pri = 1'($urandom); r.pvid = VW'($urandom); r.dvid = VW'($urandom);
            send(r, "R2-R11 mixed");
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(3);
        done = 1'b1;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R12: got %0d pending results exp 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule